// File: doc/BRIEF.md
# Grouped Wake-Up Input Detector

This block conditions up to 64 wake-up lines, arranged as eight groups of eight, for a chip's interrupt and power logic. Each line passes through a two-flop synchroniser. A small set of per-bit controls then chooses what counts as an event on that line:

- a high or low level;
- a rising or a falling edge;
- any edge.

A qualifying event latches a sticky pending bit, but only for lines whose input gate is open.

Software clears pending bits by writing ones to a clear register. Each group drives its own interrupt line, which is high while any pending bit of that group is also interrupt-enabled. The OR of the eight group lines forms a single wake request, which power control uses to leave a low-power state.

Registers are reached through a flat address of the form `{select[2:0], group[2:0]}` with one data byte. Writes use a one-cycle strobe and reads are combinational.

Top module: `wake_cond`

## Requirements
- R1: The address is `{select, group}`. The select codes are: 0 = mode, 1 = polarity, 2 = any-edge, 3 = input gate, 4 = interrupt enable, 5 = pending (read only), 6 = clear (write only, reads 0). A byte written to selects 0 to 4 reads back unchanged for the addressed group.
- R2: After reset, every register reads 0, every group interrupt is low and the wake request is low.
- R3: With mode bit 1 (level), polarity 0 detects a high level and polarity 1 detects a low level. The pending bit is set on every cycle the level holds, so a clear in that cycle has no effect.
- R4: With mode bit 0 (edge) and any-edge 0, polarity 0 detects a rising edge and polarity 1 detects a falling edge.
- R5: With mode bit 0 and any-edge 1, both edges are detected whatever the polarity bit holds.
- R6: A line whose input-gate bit is 0 never sets its pending bit.
- R7: A write that changes an input-gate bit, in either direction, sets that bit's pending flag. A later clear removes the flag.
- R8: Writing 1 to a clear bit clears that pending bit, and writing 0 leaves it unchanged. Writes to the pending select are ignored.
- R9: A group interrupt is high exactly when that group's pending AND interrupt-enable bits are non-zero.
- R10: The wake request is high exactly when at least one group interrupt is high.
- R11: A change on a wake input shows up in the pending register after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | `{select[2:0], group[2:0]}` |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| wake_in | input | 64 | Asynchronous wake-up lines; bit g*8+b is line b of group g |
| grp_irq | output | 8 | One interrupt per group |
| wake_req | output | 1 | OR of all group interrupts |

## Verification
The hardest situation to reach is a detector that settles on a stale edge or level while it is being reconfigured. Each reconfiguration writes the input gate, which is itself a source of spurious pending bits.

The sweep therefore handles each of the 32 trigger-setting and transition pairs in a fixed order:
1. It holds the line at its starting value until the previous-value register has settled.
2. It programs the controls and opens the gate.
3. It clears the spurious flag.
4. It makes the transition.

The expected pending value is then a pure function of mode, polarity, any-edge and the two line values. A level that already qualifies before the clear still leaves the bit set.

// File: rtl/wake_cond.sv
module wake_cond #(
  parameter int NGRP = 8,
  parameter int GW   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [$clog2(NGRP)+2:0]       reg_addr,
  input  logic [GW-1:0]                 reg_wdata,
  output logic [GW-1:0]                 reg_rdata,
  input  logic [NGRP*GW-1:0]            wake_in,
  output logic [NGRP-1:0]               grp_irq,
  output logic                          wake_req
);
  localparam int NB  = NGRP * GW;
  localparam int GSW = $clog2(NGRP);
  localparam logic [2:0] SEL_MODE = 3'd0, SEL_POL = 3'd1, SEL_ANY = 3'd2,
                         SEL_IEN  = 3'd3, SEL_IE  = 3'd4, SEL_PEND = 3'd5,
                         SEL_CLR  = 3'd6;

  logic [NB-1:0] s1, s2, prev;
  logic [NB-1:0] mode_r, pol_r, any_r, ien_r, ie_r, pend_r;
  logic [NB-1:0] rise, fall, lvl_hit, edg_hit, evt, clr_m, ien_chg, pend_n;
  logic [2:0]     sel;
  logic [GSW-1:0] grp;
  int unsigned    base;

  assign sel  = reg_addr[GSW+2:GSW];
  assign grp  = reg_addr[GSW-1:0];
  assign base = GW * int'(grp);

  assign rise    = s2 & ~prev;
  assign fall    = ~s2 & prev;
  assign lvl_hit = mode_r & (s2 ^ pol_r);
  assign edg_hit = ~mode_r & ((any_r & (rise | fall)) |
                              (~any_r & ((pol_r & fall) | (~pol_r & rise))));
  assign evt     = ien_r & (lvl_hit | edg_hit);

  always_comb begin
    clr_m   = '0;
    ien_chg = '0;
    if (reg_wr && sel == SEL_CLR) clr_m[base +: GW] = reg_wdata;
    if (reg_wr && sel == SEL_IEN) ien_chg[base +: GW] = reg_wdata ^ ien_r[base +: GW];
  end

  assign pend_n = (pend_r & ~clr_m) | evt | ien_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
      mode_r <= '0; pol_r <= '0; any_r <= '0;
      ien_r <= '0; ie_r <= '0; pend_r <= '0;
    end else begin
      s1     <= wake_in;
      s2     <= s1;
      prev   <= s2;
      pend_r <= pend_n;
      if (reg_wr) begin
        case (sel)
          SEL_MODE: mode_r[base +: GW] <= reg_wdata;
          SEL_POL:  pol_r[base +: GW]  <= reg_wdata;
          SEL_ANY:  any_r[base +: GW]  <= reg_wdata;
          SEL_IEN:  ien_r[base +: GW]  <= reg_wdata;
          SEL_IE:   ie_r[base +: GW]   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE: reg_rdata = mode_r[base +: GW];
      SEL_POL:  reg_rdata = pol_r[base +: GW];
      SEL_ANY:  reg_rdata = any_r[base +: GW];
      SEL_IEN:  reg_rdata = ien_r[base +: GW];
      SEL_IE:   reg_rdata = ie_r[base +: GW];
      SEL_PEND: reg_rdata = pend_r[base +: GW];
      default:  reg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    assign grp_irq[g] = |(pend_r[g*GW +: GW] & ie_r[g*GW +: GW]);
  end

  assign wake_req = |grp_irq;
endmodule

// File: rtl/wake_cond_chk.sv
module wake_cond_chk #(
  parameter int NGRP = 8,
  parameter int GW   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic [$clog2(NGRP)+2:0] reg_addr,
  input logic [GW-1:0]           reg_wdata,
  input logic [NGRP*GW-1:0]      pend,
  input logic [NGRP*GW-1:0]      ien,
  input logic [NGRP*GW-1:0]      ie,
  input logic [NGRP-1:0]         grp_irq,
  input logic                    wake_req
);
  localparam int NB  = NGRP * GW;
  localparam int GSW = $clog2(NGRP);

  logic [NB-1:0] clr_mask;
  always_comb begin
    clr_mask = '0;
    if (reg_wr && reg_addr[GSW+2:GSW] == 3'd6)
      clr_mask[GW*int'(reg_addr[GSW-1:0]) +: GW] = reg_wdata;
  end

  AST_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(ien) & ~ien) == '0);  // R6

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr_mask)) == '0);  // R8

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] |-> (ie[g*GW +: GW] != '0));  // R9
  end

  AST_WAKE_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($countones(grp_irq) > 0));  // R10

  AST_WAKE_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grp_irq) > 0) |-> wake_req);  // R10
endmodule

bind wake_cond wake_cond_chk #(.NGRP(NGRP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pend(pend_r), .ien(ien_r), .ie(ie_r),
  .grp_irq(grp_irq), .wake_req(wake_req)
);

// File: tb/tb_wake_cond.sv
`timescale 1ns/1ps
module tb_wake_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] wake_in = '0;
  logic [7:0]  grp_irq;
  logic        wake_req;
  int nvec = 0, nfail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  wake_cond dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_in(wake_in),
    .grp_irq(grp_irq), .wake_req(wake_req));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int g, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {sel[2:0], g[2:0]}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int sel, input int g, output logic [7:0] d);
    reg_addr = {sel[2:0], g[2:0]};
    #1 d = reg_rdata;
  endtask

  initial begin
    #(20 * 150000);
    nvec++; nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    #1;
    chk("R2 irq", grp_irq, 0);
    chk("R2 wake", wake_req, 0);
    for (int s = 0; s < 7; s++)
      for (int g = 0; g < 8; g++) begin
        rd(s, g, rv);
        chk("R2 regs", rv, 0);
      end

    // R1 readback of all configuration registers
    for (int s = 0; s < 5; s++)
      for (int g = 0; g < 8; g++) wr(s, g, 8'((s * 37 + g * 11 + 5) & 255));
    for (int s = 0; s < 5; s++)
      for (int g = 0; g < 8; g++) begin
        rd(s, g, rv);
        chk("R1 readback", rv, (s * 37 + g * 11 + 5) & 255);
      end
    rd(6, 0, rv);
    chk("R1 clear reads zero", rv, 0);
    for (int g = 0; g < 8; g++) wr(3, g, 8'h00);
    for (int s = 0; s < 5; s++)
      for (int g = 0; g < 8; g++) wr(s, g, 8'h00);
    for (int g = 0; g < 8; g++) wr(6, g, 8'hFF);
    for (int g = 0; g < 8; g++) begin
      rd(5, g, rv);
      chk("R7 clear after reconfig", rv, 0);
    end
    wr(5, 2, 8'hFF);
    rd(5, 2, rv);
    chk("R8 pending write ignored", rv, 0);

    // R11 latency: group 1 line 3, rising edge
    wr(3, 1, 8'h08);
    wr(6, 1, 8'hFF);
    wake_in[11] = 1'b1;
    cyc(2);
    rd(5, 1, rv);
    chk("R11 not after second edge", rv, 0);
    cyc(1);
    rd(5, 1, rv);
    chk("R11 after third edge", rv, 8'h08);
    wake_in[11] = 1'b0;
    cyc(4);
    wr(3, 1, 8'h00);
    wr(6, 1, 8'hFF);

    // R7 spurious set on input-gate change
    wr(3, 4, 8'hA5);
    rd(5, 4, rv);
    chk("R7 gate on sets pending", rv, 8'hA5);
    wr(6, 4, 8'hFF);
    rd(5, 4, rv);
    chk("R7 clear removes", rv, 0);
    wr(3, 4, 8'h00);
    rd(5, 4, rv);
    chk("R7 gate off sets pending", rv, 8'hA5);
    wr(6, 4, 8'hFF);

    // R8 partial clears
    wr(3, 5, 8'hFF);
    wr(3, 5, 8'h00);
    wr(6, 5, 8'h00);
    rd(5, 5, rv);
    chk("R8 zero clear no effect", rv, 8'hFF);
    wr(6, 5, 8'h0F);
    rd(5, 5, rv);
    chk("R8 partial clear", rv, 8'hF0);
    wr(5, 5, 8'h00);
    rd(5, 5, rv);
    chk("R8 pending write ignored", rv, 8'hF0);
    wr(6, 5, 8'hFF);

    // R9 / R10 interrupt enable and combining
    wr(3, 6, 8'h01); wr(3, 6, 8'h00);
    #1 chk("R9 no enable", grp_irq, 0);
    chk("R10 idle", wake_req, 0);
    wr(4, 6, 8'h02);
    #1 chk("R9 enable other bit", grp_irq, 0);
    wr(4, 6, 8'h01);
    #1 chk("R9 group 6 irq", grp_irq, 8'h40);
    chk("R10 wake", wake_req, 1);
    wr(3, 7, 8'h10); wr(3, 7, 8'h00); wr(4, 7, 8'h10);
    #1 chk("R9 two groups", grp_irq, 8'hC0);
    wr(6, 6, 8'hFF);
    #1 chk("R9 group 6 cleared", grp_irq, 8'h80);
    chk("R10 wake one group", wake_req, 1);
    wr(6, 7, 8'hFF);
    #1 chk("R9 all cleared", grp_irq, 0);
    chk("R10 wake drops", wake_req, 0);
    wr(4, 6, 8'h00); wr(4, 7, 8'h00);

    // R6 closed gate records nothing
    wr(2, 3, 8'h01); wr(4, 3, 8'h01);
    wake_in[24] = 1'b1; cyc(4);
    wake_in[24] = 1'b0; cyc(4);
    rd(5, 3, rv);
    chk("R6 edge ignored", rv, 0);
    wr(0, 3, 8'h01);
    wake_in[24] = 1'b1; cyc(4);
    rd(5, 3, rv);
    chk("R6 level ignored", rv, 0);
    #1 chk("R6 irq low", grp_irq, 0);
    wake_in[24] = 1'b0;
    wr(0, 3, 8'h00); wr(2, 3, 8'h00); wr(4, 3, 8'h00);
    cyc(4);

    // R3 level persists through clear
    wr(0, 2, 8'h80); wr(3, 2, 8'h80); wr(6, 2, 8'hFF);
    wake_in[23] = 1'b1; cyc(4);
    rd(5, 2, rv);
    chk("R3 high level", rv, 8'h80);
    wr(6, 2, 8'h80);
    rd(5, 2, rv);
    chk("R3 set wins over clear", rv, 8'h80);
    wake_in[23] = 1'b0; cyc(4);
    wr(6, 2, 8'h80);
    rd(5, 2, rv);
    chk("R3 clear after level gone", rv, 0);
    wr(3, 2, 8'h00); wr(0, 2, 8'h00); wr(6, 2, 8'hFF);

    // Sweep: every trigger setting against every transition (R3 R4 R5)
    for (int cfg = 0; cfg < 8; cfg++)
      for (int tr = 0; tr < 4; tr++) begin
        int idx, g, b;
        logic md, pl, an, st, en, q, e;
        logic [7:0] m;
        string tag;
        idx = (cfg * 4 + tr) * 2 + 1;
        g = idx / 8; b = idx % 8; m = 8'(1 << b);
        md = cfg[2]; pl = cfg[1]; an = cfg[0];
        st = tr[1]; en = tr[0];
        q = ~pl;
        if (md) e = (st == q) || (en == q);
        else if (an) e = (st != en);
        else e = pl ? (st & ~en) : (~st & en);
        tag = md ? "R3 level" : (an ? "R5 any edge" : "R4 edge");
        @(negedge clk); wake_in[idx] = st;
        cyc(4);
        wr(0, g, md ? m : 8'h00);
        wr(1, g, pl ? m : 8'h00);
        wr(2, g, an ? m : 8'h00);
        wr(4, g, m);
        wr(3, g, m);
        wr(6, g, 8'hFF);
        wake_in[idx] = en;
        cyc(4);
        rd(5, g, rv);
        chk(tag, rv, e ? m : 8'h00);
        chk("R9 sweep irq", grp_irq, e ? (64'd1 << g) : 64'd0);
        chk("R10 sweep wake", wake_req, e);
        wr(3, g, 8'h00); wr(4, g, 8'h00);
        wr(0, g, 8'h00); wr(1, g, 8'h00); wr(2, g, 8'h00);
        wake_in[idx] = 1'b0;
        cyc(4);
        wr(6, g, 8'hFF);
      end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule